// File: doc/BRIEF.md
# Recovered Clock Lock Detector

This block decides whether a recovered receive clock runs at the same frequency as a chosen reference clock. All four clock inputs are sampled by a fast system clock `clk`. Each input passes through a two-stage synchronizer and a rising-edge detector. The reference can be one of three sources:

- a crystal clock;
- a parallel transmit clock;
- a bit-rate serial transmit clock, divided by eight before use.

A measurement window spans `2**WIN_LOG2` reference edges. During that window the block counts rising edges of the recovered clock. When the window closes, it compares that count against the ideal count, with a tolerance of `TOL`. The defaults are a window of 16384 reference edges and a tolerance of 8 counts, which is about 488 ppm.

A small state machine filters the window verdicts into a `lock` level. It has four states:

- **ST_UNLOCK**: a good window moves it to ST_PEND.
- **ST_PEND**: a good window moves it to ST_LOCKED; a bad window moves it back to ST_UNLOCK.
- **ST_LOCKED**: a bad window moves it to ST_UNLOCK.
- **ST_HOLD**: entered from any state whenever a transmit clock is the reference and transmit monitoring is off. It returns to ST_LOCKED or ST_UNLOCK according to the held lock level.

Any change of `lock` sets a sticky `irq` bit, which stays set until `irq_clr` is pulsed. Changing `ref_sel` does not change `lock`; it throws away the window in progress and starts a new one.

Top module: `clk_lock_monitor`

## Requirements
- R1: `lock` rises only after two consecutive complete windows in which the recovered edge count differs from `2**WIN_LOG2` by at most `TOL`.
- R2: While locked, a single complete window whose count lies outside that band clears `lock` at the edge that closes the window.
- R3: `ref_sel` encoding: 2'b00 selects the crystal clock, 2'b01 the parallel transmit clock, 2'b10 the serial transmit clock, and 2'b11 the crystal clock.
- R4: With `ref_sel`=2'b10, one reference edge is counted for every eight rising edges of `txser_clk`.
- R5: With a transmit reference selected (01 or 10) and `mon_en`=0, measurement is suspended and `lock` keeps its value, whatever the recovered clock does.
- R6: With a transmit reference selected and `remote_lb`=1, measurement is suspended and `lock` keeps its value, even when `mon_en`=1.
- R7: With the crystal reference selected, measurement runs whatever the values of `mon_en` and `remote_lb`.
- R8: `irq` is set on every change of `lock`. It stays set until an `irq_clr` pulse, and it reads 0 one edge after that pulse unless `lock` changed at the same edge.
- R9: While `rst_n` is low, `lock` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low reset |
| xtal_clk | input | 1 | Crystal reference clock |
| txpar_clk | input | 1 | Parallel transmit clock |
| txser_clk | input | 1 | Serial transmit clock, divided by 8 inside |
| rec_clk | input | 1 | Recovered clock under test |
| ref_sel | input | 2 | Reference source select |
| mon_en | input | 1 | Enables measurement against transmit references |
| remote_lb | input | 1 | Remote loopback; suspends transmit-reference measurement |
| irq_clr | input | 1 | One-cycle strobe that clears `irq` |
| lock | output | 1 | Frequency lock status |
| irq | output | 1 | Sticky lock-change flag |

## Verification
A clock edge reaches the window counters three `clk` cycles after it arrives, so `lock` can only change at the edge that closes a window, one window length after the previous close. For that reason the bench never samples `lock` at a guessed edge. After each stimulus it waits a whole number of windows plus a margin, then samples. The `irq` flag is checked twice: at the same sample point, and again one edge after the clear strobe. `lock` is stable at both points, so the cleared value is certain.

// File: rtl/clk_lock_pkg.sv
package clk_lock_pkg;

    typedef enum logic [1:0] {
        SRC_XTAL  = 2'b00,
        SRC_TXPAR = 2'b01,
        SRC_TXSER = 2'b10,
        SRC_ALT   = 2'b11
    } ref_src_e;

    typedef enum logic [1:0] {
        ST_UNLOCK,
        ST_PEND,
        ST_LOCKED,
        ST_HOLD
    } lock_state_e;

endpackage

// File: rtl/lck_edge_sync.sv
module lck_edge_sync #(
    parameter int N      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] rise_o
);
    // Synchronizer stages, plus one more flop used for edge detection
    for (genvar g = 0; g < N; g++) begin : g_bit
        logic [STAGES:0] sh;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh <= '0;
            else        sh <= {sh[STAGES-1:0], async_i[g]};
        end
        assign rise_o[g] = sh[STAGES-1] & ~sh[STAGES];
    end
endmodule

// File: rtl/lck_ref_select.sv
module lck_ref_select
    import clk_lock_pkg::*;
#(
    parameter int SER_DIV = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       xtal_rise,
    input  logic       txpar_rise,
    input  logic       txser_rise,
    input  logic [1:0] ref_sel,
    input  logic       mon_en,
    input  logic       remote_lb,
    output logic       ref_tick,
    output logic       hold
);
    localparam int DW = $clog2(SER_DIV);

    logic [DW-1:0] div_q;
    logic          ser_tick;
    logic          tx_sel;
    ref_src_e      src;

    assign src      = ref_src_e'(ref_sel);
    assign ser_tick = txser_rise && (div_q == DW'(SER_DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          div_q <= '0;
        else if (ser_tick)   div_q <= '0;
        else if (txser_rise) div_q <= div_q + 1'b1;
    end

    always_comb begin
        unique case (src)
            SRC_TXPAR: ref_tick = txpar_rise;
            SRC_TXSER: ref_tick = ser_tick;
            SRC_XTAL,
            SRC_ALT:   ref_tick = xtal_rise;
        endcase
    end

    assign tx_sel = (src == SRC_TXPAR) || (src == SRC_TXSER);
    assign hold   = tx_sel && !(mon_en && !remote_lb);
endmodule

// File: rtl/lck_window.sv
module lck_window #(
    parameter int WIN_LOG2 = 14,
    parameter int TOL      = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic ref_tick,
    input  logic rec_tick,
    output logic win_done,
    output logic in_range
);
    localparam int          CW  = WIN_LOG2 + 2;
    localparam int          WIN = 1 << WIN_LOG2;
    localparam logic [CW:0] LO  = (CW+1)'(WIN - TOL);
    localparam logic [CW:0] HI  = (CW+1)'(WIN + TOL);

    logic [WIN_LOG2-1:0] ref_cnt;
    logic [CW-1:0]       rec_cnt;
    logic [CW:0]         rec_total;

    assign win_done  = ref_tick && (&ref_cnt);
    assign rec_total = {1'b0, rec_cnt} + (CW+1)'(rec_tick);
    assign in_range  = (rec_total >= LO) && (rec_total <= HI);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_cnt <= '0;
            rec_cnt <= '0;
        end else if (restart) begin
            ref_cnt <= '0;
            rec_cnt <= '0;
        end else begin
            if (ref_tick) ref_cnt <= ref_cnt + 1'b1;
            if (win_done)
                rec_cnt <= '0;
            else if (rec_tick && !(&rec_cnt))
                rec_cnt <= rec_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/clk_lock_monitor.sv
module clk_lock_monitor
    import clk_lock_pkg::*;
#(
    parameter int WIN_LOG2 = 14,
    parameter int TOL      = 8,
    parameter int SER_DIV  = 8,
    parameter int STAGES   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       xtal_clk,
    input  logic       txpar_clk,
    input  logic       txser_clk,
    input  logic       rec_clk,
    input  logic [1:0] ref_sel,
    input  logic       mon_en,
    input  logic       remote_lb,
    input  logic       irq_clr,
    output logic       lock,
    output logic       irq
);
    logic [3:0]  rise;
    logic        ref_tick;
    logic        hold;
    logic        win_done;
    logic        in_range;
    logic        restart;
    logic [1:0]  sel_q;
    logic        lock_q;
    logic        lock_d;
    logic        irq_q;
    lock_state_e state_q;
    lock_state_e state_d;

    lck_edge_sync #(.N(4), .STAGES(STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({rec_clk, txser_clk, txpar_clk, xtal_clk}),
        .rise_o  (rise)
    );

    lck_ref_select #(.SER_DIV(SER_DIV)) u_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .xtal_rise  (rise[0]),
        .txpar_rise (rise[1]),
        .txser_rise (rise[2]),
        .ref_sel    (ref_sel),
        .mon_en     (mon_en),
        .remote_lb  (remote_lb),
        .ref_tick   (ref_tick),
        .hold       (hold)
    );

    assign restart = hold || (ref_sel != sel_q);

    lck_window #(.WIN_LOG2(WIN_LOG2), .TOL(TOL)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .ref_tick (ref_tick),
        .rec_tick (rise[3]),
        .win_done (win_done),
        .in_range (in_range)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_UNLOCK;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (hold) begin
            state_d = ST_HOLD;
        end else begin
            unique case (state_q)
                ST_HOLD:   state_d = lock_q ? ST_LOCKED : ST_UNLOCK;
                ST_UNLOCK: if (win_done && in_range) state_d = ST_PEND;
                ST_PEND:   if (win_done) state_d = in_range ? ST_LOCKED : ST_UNLOCK;
                ST_LOCKED: if (win_done && !in_range) state_d = ST_UNLOCK;
            endcase
        end
    end

    assign lock_d = (state_d == ST_LOCKED) || ((state_d == ST_HOLD) && lock_q);

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_q <= 1'b0;
            irq_q  <= 1'b0;
            sel_q  <= '0;
        end else begin
            lock_q <= lock_d;
            irq_q  <= (lock_d != lock_q) || (irq_q && !irq_clr);
            sel_q  <= ref_sel;
        end
    end

    assign lock = lock_q;
    assign irq  = irq_q;
endmodule

// File: rtl/clk_lock_monitor_chk.sv
module clk_lock_monitor_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] ref_sel,
    input logic       mon_en,
    input logic       remote_lb,
    input logic       irq_clr,
    input logic       lock,
    input logic       irq
);
    logic tx_sel;
    assign tx_sel = (ref_sel == 2'b01) || (ref_sel == 2'b10);

    assert_irq_on_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lock != $past(lock)) |-> irq);

    assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq);

    assert_irq_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clr |=> (irq == (lock != $past(lock))));

    assert_hold_mon_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_sel && !mon_en) |=> $stable(lock));

    assert_hold_loopback_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_sel && remote_lb) |=> $stable(lock));

    always_comb begin
        if (!rst_n) begin
            assert_reset_R9: assert (!lock && !irq);
        end
    end
endmodule

bind clk_lock_monitor clk_lock_monitor_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_sel   (ref_sel),
    .mon_en    (mon_en),
    .remote_lb (remote_lb),
    .irq_clr   (irq_clr),
    .lock      (lock),
    .irq       (irq)
);

// File: tb/clk_lock_monitor_tb_top.sv
`timescale 1ns/100ps
module clk_lock_monitor_tb_top;
    localparam int WL    = 6;
    localparam int WIN_C = (1 << WL) * 32;  // sys cycles per crystal window
    localparam int NV    = 13;

    // Stimulus table: select, mon_en, remote_lb, rec offset, windows, expected lock
    localparam int V_SEL [NV] = '{0, 0, 0, 1, 1, 2, 2, 2, 2, 2, 2, 0, 0};
    localparam int V_MON [NV] = '{1, 1, 1, 1, 1, 1, 1, 1, 0, 1, 1, 0, 0};
    localparam int V_LB  [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 1};
    localparam int V_D   [NV] = '{0, 6, -1, 0, 8, 0, -6, 0, 6, 6, 6, 0, 6};
    localparam int V_W   [NV] = '{4, 3, 4, 3, 4, 4, 3, 4, 4, 4, 3, 4, 3};
    localparam int V_EXP [NV] = '{1, 0, 1, 0, 1, 1, 0, 1, 1, 1, 0, 1, 0};
    localparam string V_REQ [NV] = '{"R1", "R2", "R1", "R3", "R3", "R4", "R4",
                                     "R4", "R5", "R6", "R2", "R7", "R7"};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] ref_sel = 2'b00;
    logic       mon_en = 1'b1;
    logic       remote_lb = 1'b0;
    logic       irq_clr = 1'b0;
    logic       lock, irq;
    logic [15:0] xt_acc = '0, tp_acc = '0, ts_acc = '0, rc_acc = '0;
    int          rec_inc = 2048;
    int          n_run = 0, n_fail = 0;
    bit          finished = 1'b0;

    always #2.5 clk = ~clk;

    // Numerically controlled clock sources (period 32 cycles for crystal)
    always @(posedge clk) begin
        xt_acc <= xt_acc + 16'd2048;
        tp_acc <= tp_acc + 16'd2304;
        ts_acc <= ts_acc + 16'd16384;
        rc_acc <= rc_acc + 16'(rec_inc);
    end

    clk_lock_monitor #(.WIN_LOG2(WL), .TOL(2)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .xtal_clk  (xt_acc[15]),
        .txpar_clk (tp_acc[15]),
        .txser_clk (ts_acc[15]),
        .rec_clk   (rc_acc[15]),
        .ref_sel   (ref_sel),
        .mon_en    (mon_en),
        .remote_lb (remote_lb),
        .irq_clr   (irq_clr),
        .lock      (lock),
        .irq       (irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got 0 expected 1 (run did not end)");
        finish_run();
    end

    initial begin
        int prev = 0;
        repeat (10) @(negedge clk);
        chk("R9 lock in reset", int'(lock), 0);
        chk("R9 irq in reset", int'(irq), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R9 lock after reset", int'(lock), 0);

        for (int v = 0; v < NV; v++) begin
            ref_sel   = 2'(V_SEL[v]);
            mon_en    = V_MON[v][0];
            remote_lb = V_LB[v][0];
            rec_inc   = 2048 + 32 * V_D[v];
            repeat (V_W[v] * WIN_C + 100) @(negedge clk);
            chk({V_REQ[v], " lock"}, int'(lock), V_EXP[v]);
            chk("R8 irq after vector", int'(irq), int'(V_EXP[v] != prev));
            irq_clr = 1'b1;
            @(negedge clk);
            irq_clr = 1'b0;
            chk("R8 irq after clear", int'(irq), 0);
            prev = V_EXP[v];
        end

        // Directed: strobe while nothing changes keeps irq clear (R8)
        repeat (50) @(negedge clk);
        chk("R8 irq stays clear", int'(irq), 0);
        // Directed: alternate crystal code 2'b11 measures against crystal (R3)
        ref_sel   = 2'b11;
        remote_lb = 1'b0;
        rec_inc   = 2048;
        repeat (4 * WIN_C + 100) @(negedge clk);
        chk("R3 code 11 uses crystal", int'(lock), 1);
        chk("R8 irq on re-lock", int'(irq), 1);
        finish_run();
    end
endmodule